// File: doc/BRIEF.md
# Two-Level Lookahead 32-Bit Adder

This block adds two 32-bit operands and a carry-in. It returns a 32-bit sum and a carry-out, and it is purely combinational. The operand is cut into four slices of eight bits. Inside each slice, every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). The carry into every bit of the slice is then written out as a flat sum of products of these terms and the slice carry-in, so no carry ripples inside a slice. Each slice also reports a group generate and a group propagate.

A second lookahead level takes the four group pairs and the adder carry-in. From them it forms the carries into bits 8, 16 and 24 and the final carry-out, each as a flat expression, so that no carry passes from slice to slice. A build-time parameter swaps this second level for a plain chain, in which each slice's carry-out feeds the next slice. The chain exists so the two forms can be compared. Both forms must give the same results.

Top module: `cla2_adder32`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i + carry_i`, read as unsigned numbers, for any operands.
- R2: `carry_o` equals bit 32 of that 33-bit unsigned total.
- R3: Each 8-bit slice's group generate and group propagate satisfy the following: the carry out of the slice equals group generate OR (group propagate AND slice carry-in). The carry out of the slice is the carry its own internal lookahead forms into its top bit plus one.
- R4: The carries into bits 8, 16 and 24, and the carry-out, all come from the second lookahead level. Each one equals the carry-out that the slice below it forms internally.
- R5: With `USE_LOOKAHEAD` = 0, carries pass slice to slice. Sum and carry-out are then identical to those of the lookahead form for every input.
- R6: All-ones plus a carry-in of 1 (or plus one with carry-in 0) carries through all four slices: sum 0, carry-out 1.
- R7: The alternating patterns 0xAAAAAAAA + 0x55555555 give 0xFFFFFFFF with carry-out 0 when carry-in is 0. They give 0 with carry-out 1 when carry-in is 1.
- R8: A carry made only in one slice reaches the next slice. Examples are 0x000000FF + 1 giving 0x00000100, and 0x80000000 + 0x80000000 giving 0 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum, low 32 bits |
| carry_o | output | 1 | Carry out of bit 31 |

## Verification
Random operand pairs with random carry-in exercise every mix of generate and propagate across slice boundaries. They are applied to a lookahead instance and a chained instance at once, which separates a faulty second-level term from a faulty slice term. All-ones plus one and the alternating patterns make every propagate term high, so a missing product term in any carry expression changes the sum. Single-slice generate cases (0xFF + 1, top-bit doubling) show whether one slice's carry reaches the next.

// File: rtl/adder_pkg.sv
package adder_pkg;
    localparam int unsigned DEF_WIDTH = 32;
    localparam int unsigned DEF_BLK_W = 8;

    typedef struct packed {
        logic gen;
        logic prop;
    } grp_pg_t;
endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int unsigned BLK_W = 8
) (
    input  logic [BLK_W-1:0] x_i,
    input  logic [BLK_W-1:0] y_i,
    input  logic             cin_i,
    output logic [BLK_W-1:0] s_o,
    output adder_pkg::grp_pg_t grp_o,
    output logic             cout_int_o
);
    logic [BLK_W-1:0] g_bit;
    logic [BLK_W-1:0] p_bit;
    logic [BLK_W:0]   c_bit;

    // per-bit generate / propagate
    always_comb begin
        g_bit = x_i & y_i;
        p_bit = x_i | y_i;
    end

    // fully expanded internal carries: c[i+1] = OR_k g[k]&p[k+1..i] | p[0..i]&cin
    always_comb begin
        c_bit[0] = cin_i;
        for (int i = 0; i < BLK_W; i++) begin
            logic acc;
            logic chain;
            chain = cin_i;
            for (int m = 0; m <= i; m++) chain = chain & p_bit[m];
            acc = chain;
            for (int k = 0; k <= i; k++) begin
                logic term;
                term = g_bit[k];
                for (int m = k + 1; m <= i; m++) term = term & p_bit[m];
                acc = acc | term;
            end
            c_bit[i+1] = acc;
        end
    end

    // group generate / propagate, independent of carry-in
    always_comb begin
        logic gacc;
        logic pacc;
        gacc = 1'b0;
        pacc = 1'b1;
        for (int k = 0; k < BLK_W; k++) begin
            logic term;
            term = g_bit[k];
            for (int m = k + 1; m < BLK_W; m++) term = term & p_bit[m];
            gacc = gacc | term;
            pacc = pacc & p_bit[k];
        end
        grp_o.gen  = gacc;
        grp_o.prop = pacc;
    end

    assign s_o        = x_i ^ y_i ^ c_bit[BLK_W-1:0];
    assign cout_int_o = c_bit[BLK_W];

    // group terms must reproduce the slice's own top carry
    always_comb begin
        assert_group_pg_R3: assert (cout_int_o == (grp_o.gen | (grp_o.prop & cin_i)))
            else $error("R3: group generate/propagate disagree with internal carry");
    end
endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit #(
    parameter int unsigned NBLK = 4
) (
    input  adder_pkg::grp_pg_t grp_i [NBLK],
    input  logic               cin_i,
    output logic [NBLK:0]      c_o
);
    // c[j+1] = OR_k G[k]&P[k+1..j] | P[0..j]&cin
    always_comb begin
        c_o[0] = cin_i;
        for (int j = 0; j < NBLK; j++) begin
            logic acc;
            logic chain;
            chain = cin_i;
            for (int m = 0; m <= j; m++) chain = chain & grp_i[m].prop;
            acc = chain;
            for (int k = 0; k <= j; k++) begin
                logic term;
                term = grp_i[k].gen;
                for (int m = k + 1; m <= j; m++) term = term & grp_i[m].prop;
                acc = acc | term;
            end
            c_o[j+1] = acc;
        end
    end
endmodule

// File: rtl/cla2_adder32.sv
module cla2_adder32 #(
    parameter int unsigned WIDTH         = adder_pkg::DEF_WIDTH,
    parameter int unsigned BLK_W         = adder_pkg::DEF_BLK_W,
    parameter bit          USE_LOOKAHEAD = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    localparam int unsigned NBLK = WIDTH / BLK_W;

    adder_pkg::grp_pg_t grp      [NBLK];
    logic [NBLK-1:0]    blk_cout;
    logic [NBLK:0]      blk_cin;

    for (genvar j = 0; j < NBLK; j++) begin : g_slice
        cla_slice #(.BLK_W(BLK_W)) u_slice (
            .x_i        (a_i[j*BLK_W +: BLK_W]),
            .y_i        (b_i[j*BLK_W +: BLK_W]),
            .cin_i      (blk_cin[j]),
            .s_o        (sum_o[j*BLK_W +: BLK_W]),
            .grp_o      (grp[j]),
            .cout_int_o (blk_cout[j])
        );

        // second-level carry into slice j+1 must match slice j's own carry-out
        always_comb begin
            assert_block_carry_R4: assert (blk_cin[j+1] == blk_cout[j])
                else $error("R4: block carry %0d mismatch", j + 1);
        end
    end

    if (USE_LOOKAHEAD) begin : g_lookahead
        cla_group_unit #(.NBLK(NBLK)) u_group (
            .grp_i (grp),
            .cin_i (carry_i),
            .c_o   (blk_cin)
        );
    end else begin : g_ripple
        always_comb begin
            logic c;
            c = carry_i;
            blk_cin[0] = carry_i;
            for (int j = 0; j < NBLK; j++) begin
                c = grp[j].gen | (grp[j].prop & c);
                blk_cin[j+1] = c;
            end
        end
    end

    assign carry_o = blk_cin[NBLK];

    always_comb begin
        assert_sum_R1: assert (sum_o == WIDTH'(a_i + b_i + WIDTH'(carry_i)))
            else $error("R1: sum differs from arithmetic total");
        assert_carry_out_R2: assert (carry_o ==
            ((({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}) >> WIDTH) != 0))
            else $error("R2: carry-out differs from arithmetic total");
    end
endmodule

// File: tb/cla2_adder32_test.sv
module cla2_adder32_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic        cin;
    logic [31:0] sum_la, sum_rp;
    logic        co_la, co_rp;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [31:0] exp_sum;
        logic        exp_co;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk; // 50 MHz

    cla2_adder32 #(.USE_LOOKAHEAD(1'b1)) uut (
        .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum_la), .carry_o(co_la));
    cla2_adder32 #(.USE_LOOKAHEAD(1'b0)) uut_rip (
        .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum_rp), .carry_o(co_rp));

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: apply on falling edge, push expectation
    task automatic drive(input logic [31:0] va, input logic [31:0] vb, input logic vc, input string req);
        item_t it;
        logic [32:0] tot;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        tot = {1'b0, va} + {1'b0, vb} + {32'd0, vc};
        it.a = va; it.b = vb; it.cin = vc;
        it.exp_sum = tot[31:0]; it.exp_co = tot[32]; it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compare on rising edge, half a period after drive
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check({co_la, sum_la} == {it.exp_co, it.exp_sum}, {it.req, " R1/R2 lookahead"},
                  {co_la, sum_la}, {it.exp_co, it.exp_sum});
            check({co_rp, sum_rp} == {co_la, sum_la}, "R5 chained equals lookahead",
                  {co_rp, sum_rp}, {co_la, sum_la});
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // reset-time state: zero inputs give zero outputs (R1, R2)
        check({co_la, sum_la} == 33'd0, "R1 zero inputs", {co_la, sum_la}, 33'd0);
        rst_n = 1'b1;
        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6 ones+cin");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6 ones+1");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R7 alt cin0");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 alt cin1");
        drive(32'h5555_5555, 32'h5555_5555, 1'b1, "R7 alt double");
        drive(32'h0000_00FF, 32'h0000_0001, 1'b0, "R8 slice0 to 1");
        drive(32'h00FF_0000, 32'h0001_0000, 1'b0, "R8 slice2 to 3");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 top generate");
        drive(32'h0000_FFFF, 32'h0000_0000, 1'b1, "R8 two slices via cin");
        for (int i = 0; i < 300; i++)
            drive($urandom, $urandom, 1'($urandom), "R3 R4 random");
        @(negedge clk);
        @(posedge clk);
        #1;
        check(sb_q.size() == 0, "R1 scoreboard drained", 33'(sb_q.size()), 33'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 33'd0, 33'd1);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule